// File: doc/BRIEF.md
# Programming-Interface Session Controller

This block opens and closes a debug or programming session on an attached target device. It sits next to a serial transceiver that does the byte framing. The block itself only decides when the data, clock and reset pins are driven, held or released, and which way the link points. A host starts a session with a one-cycle start command and a mode bit, and ends it with a stop command. It can also ask the block to turn the link around to wait for a reply byte, or to point it back toward the target. The block tells the host it is working through a busy output, reports each finished step with a done pulse, and reports a lost target with a sticky timeout flag.

Two pin arrangements are supported. In the two-wire arrangement the clock pin also acts as the target's reset, and the data pin must be held high for a short time to switch the reset function off. In the three-wire arrangement a separate active-low reset pin is held low for the whole session. In both arrangements the entry ends with idle frames sent with the data line high, which wakes the target's debug port. Minimum times shorter than a millisecond are worked out from the system clock period and rounded up to whole cycles. Longer waits count an external millisecond strobe.

Top module: `prog_session_ctrl`

## Requirements
- R1: After reset, and whenever no session is open, every pin is released: `data_oe`, `sclk_oe`, `sclk_run`, `sclk_force_hi` and `tgt_rst_low` are all 0, and `busy`, `done`, `tmo_flag` and `session_on` are 0.
- R2: An accepted start with `cmd_mode`=0 (two-wire) holds the data pin driven high (`data_oe`=1, `data_hold_hi`=1) with the clock stopped for at least ceil(DATA_HI_NS/clock period) cycles (23 at defaults) before `sclk_run` first rises. `tgt_rst_low` stays 0 for the whole session.
- R3: An accepted start with `cmd_mode`=1 (three-wire) drives `tgt_rst_low`=1 for at least ceil(RST_LO_NS/clock period) cycles (100 at defaults) before `sclk_run` first rises. It keeps `tgt_rst_low`=1 until the session closes.
- R4: After the setup time the clock runs with the data pin held high for BREAK_COUNT×BREAK_BITS `bit_tick` strobes (24 at defaults). Then `done` pulses for one cycle, and the session is open and idle in the transmit direction (`link_dir_tx`=1, `busy`=0).
- R5: An `rx_req` while transmitting keeps the data pin driven until `tx_busy` is low, then releases it. The block then waits for the synchronised `data_in` to read high, and gives up after TMO_MS (100) `ms_tick` strobes.
- R6: While a byte is awaited, `frame_done` ends the wait with a `done` pulse and an open session in the receive direction. TMO_MS `ms_tick` strobes without it end the wait as a timeout, and 99 strobes do not.
- R7: A timeout sets `tmo_flag`, closes the session and releases all pins at once. The flag stays set until the next accepted start, which clears it.
- R8: A `cmd_stop` first waits for `tx_busy` to be low while keeping the data pin as it was, and then releases the data pin.
- R9: In two-wire mode, after the drain the clock pin is driven high with the clock stopped (`sclk_force_hi`=1) until the second `ms_tick`. Then every pin is released and `done` pulses.
- R10: In three-wire mode, after the drain every pin, including the reset pin, is released at once and `done` pulses.
- R11: `busy` is 1 during entry, turnaround, byte wait and exit. While it is 1, `cmd_start` and `cmd_stop` have no effect.
- R12: In an open session `tx_req` sets the transmit direction and drives the data pin. An `rx_req` made while already receiving goes straight to the byte wait without touching the data pin.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_start | input | 1 | Open a session (accepted only with no session open) |
| cmd_mode | input | 1 | Mode sampled with start: 0 two-wire, 1 three-wire |
| cmd_stop | input | 1 | Close the open session |
| rx_req | input | 1 | Turn the link to receive and await one byte |
| tx_req | input | 1 | Point the link toward the target |
| bit_tick | input | 1 | One strobe per serial bit period |
| ms_tick | input | 1 | One strobe per millisecond |
| tx_busy | input | 1 | Transceiver still has bits to send |
| frame_done | input | 1 | Transceiver has received a complete frame |
| data_in | input | 1 | Data pin level as read back (asynchronous) |
| data_oe | output | 1 | Drive the data pin |
| data_hold_hi | output | 1 | Force the driven data pin high instead of the transceiver bit |
| link_dir_tx | output | 1 | Transceiver direction: 1 transmit, 0 receive |
| sclk_oe | output | 1 | Drive the clock pin |
| sclk_run | output | 1 | Let the transceiver toggle the clock pin |
| sclk_force_hi | output | 1 | Hold the driven clock pin high |
| tgt_rst_low | output | 1 | Drive the separate reset pin low (three-wire) |
| session_on | output | 1 | A session is open or being opened or closed |
| busy | output | 1 | Commands are held off |
| done | output | 1 | One-cycle pulse: entry, byte wait or exit finished |
| tmo_flag | output | 1 | Sticky timeout status |

## Verification
The main sequence is tried in both pin modes under three target behaviours. In the first the target pulls the line up and returns a frame. In the second it pulls the line up but stays silent. In the third it never releases the line. Together these separate a completed byte wait from a timeout in the byte wait and from a timeout in the turnaround wait, and show that each mode gives the right reset-pin and setup length. The timeout is tried at 99 and at 100 strobes to pin down the edge. Directed cases cover commands sent while busy, a drain that holds while `tx_busy` stays high, a second receive request while already receiving, and clearing of the sticky flag.

// File: rtl/prog_session_pkg.sv
package prog_session_pkg;

   typedef enum logic [3:0] {
      S_IDLE,
      S_ENT_SETUP,
      S_ENT_BRK,
      S_ACTIVE,
      S_TURN_DRAIN,
      S_TURN_WAITHI,
      S_RX_WAIT,
      S_EXIT_DRAIN,
      S_EXIT_HOLD
   } sess_state_e;

   // whole clock cycles covering a duration in ns, rounded up
   function automatic int ns_to_cyc(input int ns, input int period_ps);
      return (ns * 1000 + period_ps - 1) / period_ps;
   endfunction

   function automatic int max_of(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/psc_sync.sv
module psc_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   generate
      if (STAGES < 0) begin : g_bad
         $error("psc_sync: STAGES must not be negative");
      end
      if (STAGES == 0) begin : g_bypass
         assign q = d;
      end else if (STAGES == 1) begin : g_one
         logic r_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) r_q <= 1'b0;
            else        r_q <= d;
         end
         assign q = r_q;
      end else begin : g_chain
         logic [STAGES-1:0] r_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) r_q <= '0;
            else        r_q <= {r_q[STAGES-2:0], d};
         end
         assign q = r_q[STAGES-1];
      end
   endgenerate
endmodule

// File: rtl/psc_evt_cnt.sv
module psc_evt_cnt #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr,
   input  logic         inc,
   input  logic [W-1:0] limit,
   output logic         reached
);
   localparam logic [W-1:0] SAT = {W{1'b1}};

   generate
      if (W < 1) begin : g_bad
         $error("psc_evt_cnt: W must be at least 1");
      end
   endgenerate

   logic [W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                    cnt_q <= '0;
      else if (clr)                  cnt_q <= '0;
      else if (inc && cnt_q != SAT)  cnt_q <= cnt_q + 1'b1;
   end

   assign reached = (cnt_q >= limit);
endmodule

// File: rtl/psc_pin_map.sv
module psc_pin_map
   import prog_session_pkg::*;
(
   input  sess_state_e state,
   input  logic        mode3,
   input  logic        link_tx,
   output logic        data_oe,
   output logic        data_hold_hi,
   output logic        sclk_oe,
   output logic        sclk_run,
   output logic        sclk_force_hi,
   output logic        tgt_rst_low
);
   logic entry, xmit_ok, open_s;

   always_comb begin
      entry   = (state == S_ENT_SETUP) || (state == S_ENT_BRK);
      xmit_ok = (state == S_ACTIVE) || (state == S_TURN_DRAIN) ||
                (state == S_EXIT_DRAIN);
      open_s  = (state != S_IDLE);

      data_oe       = entry || (xmit_ok && link_tx);
      data_hold_hi  = entry;
      sclk_oe       = open_s;
      sclk_run      = open_s && (state != S_ENT_SETUP) && (state != S_EXIT_HOLD);
      sclk_force_hi = (state == S_EXIT_HOLD);
      tgt_rst_low   = open_s && mode3;
   end
endmodule

// File: rtl/prog_session_ctrl.sv
module prog_session_ctrl
   import prog_session_pkg::*;
#(
   parameter int CLK_PERIOD_PS = 4000,
   parameter int DATA_HI_NS    = 90,
   parameter int RST_LO_NS     = 400,
   parameter int BREAK_BITS    = 12,
   parameter int BREAK_COUNT   = 2,
   parameter int TMO_MS        = 100,
   parameter int HOLD_MS       = 2,
   parameter int SYNC_STAGES   = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic cmd_start,
   input  logic cmd_mode,
   input  logic cmd_stop,
   input  logic rx_req,
   input  logic tx_req,
   input  logic bit_tick,
   input  logic ms_tick,
   input  logic tx_busy,
   input  logic frame_done,
   input  logic data_in,
   output logic data_oe,
   output logic data_hold_hi,
   output logic link_dir_tx,
   output logic sclk_oe,
   output logic sclk_run,
   output logic sclk_force_hi,
   output logic tgt_rst_low,
   output logic session_on,
   output logic busy,
   output logic done,
   output logic tmo_flag
);
   localparam int DATA_HI_CYC = ns_to_cyc(DATA_HI_NS, CLK_PERIOD_PS);
   localparam int RST_LO_CYC  = ns_to_cyc(RST_LO_NS, CLK_PERIOD_PS);
   localparam int BRK_TOTAL   = BREAK_BITS * BREAK_COUNT;
   localparam int MAX_LIM     = max_of(max_of(DATA_HI_CYC, RST_LO_CYC),
                                       max_of(BRK_TOTAL, max_of(TMO_MS, HOLD_MS)));
   localparam int CW          = $clog2(MAX_LIM + 2);

   generate
      if (CLK_PERIOD_PS < 1 || BREAK_BITS < 1 || BREAK_COUNT < 1 ||
          TMO_MS < 1 || HOLD_MS < 1) begin : g_bad_cfg
         $error("prog_session_ctrl: durations and counts must be positive");
      end
   endgenerate

   sess_state_e    state_q, state_d;
   logic           link_q, link_d;
   logic           mode_q;
   logic           done_d, tmo_set;
   logic           start_ok;
   logic           cnt_inc, cnt_reached;
   logic [CW-1:0]  cnt_limit;
   logic           data_s;

   psc_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (data_in),
      .q     (data_s)
   );

   // one counter serves every timed phase; it restarts on each state change
   psc_evt_cnt #(.W(CW)) u_cnt (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr     (state_d != state_q),
      .inc     (cnt_inc),
      .limit   (cnt_limit),
      .reached (cnt_reached)
   );

   always_comb begin
      cnt_inc   = 1'b0;
      cnt_limit = CW'(MAX_LIM + 1);
      unique case (state_q)
         S_ENT_SETUP: begin
            cnt_inc   = 1'b1;
            cnt_limit = mode_q ? CW'(RST_LO_CYC) : CW'(DATA_HI_CYC);
         end
         S_ENT_BRK: begin
            cnt_inc   = bit_tick;
            cnt_limit = CW'(BRK_TOTAL);
         end
         S_TURN_WAITHI, S_RX_WAIT: begin
            cnt_inc   = ms_tick;
            cnt_limit = CW'(TMO_MS);
         end
         S_EXIT_HOLD: begin
            cnt_inc   = ms_tick;
            cnt_limit = CW'(HOLD_MS);
         end
         default: ;
      endcase
   end

   always_comb begin
      state_d  = state_q;
      link_d   = link_q;
      done_d   = 1'b0;
      tmo_set  = 1'b0;
      start_ok = 1'b0;
      unique case (state_q)
         S_IDLE: begin
            link_d = 1'b0;
            if (cmd_start) begin
               start_ok = 1'b1;
               state_d  = S_ENT_SETUP;
            end
         end
         S_ENT_SETUP: if (cnt_reached) state_d = S_ENT_BRK;
         S_ENT_BRK: if (cnt_reached) begin
            state_d = S_ACTIVE;
            link_d  = 1'b1;
            done_d  = 1'b1;
         end
         S_ACTIVE: begin
            if (cmd_stop)     state_d = S_EXIT_DRAIN;
            else if (rx_req)  state_d = link_q ? S_TURN_DRAIN : S_RX_WAIT;
            else if (tx_req)  link_d  = 1'b1;
         end
         S_TURN_DRAIN: if (!tx_busy) begin
            state_d = S_TURN_WAITHI;
            link_d  = 1'b0;
         end
         S_TURN_WAITHI: begin
            if (data_s) state_d = S_RX_WAIT;
            else if (cnt_reached) begin
               state_d = S_IDLE;
               tmo_set = 1'b1;
            end
         end
         S_RX_WAIT: begin
            if (frame_done) begin
               state_d = S_ACTIVE;
               done_d  = 1'b1;
            end else if (cnt_reached) begin
               state_d = S_IDLE;
               tmo_set = 1'b1;
            end
         end
         S_EXIT_DRAIN: if (!tx_busy) begin
            link_d = 1'b0;
            if (mode_q) begin
               state_d = S_IDLE;
               done_d  = 1'b1;
            end else begin
               state_d = S_EXIT_HOLD;
            end
         end
         S_EXIT_HOLD: if (cnt_reached) begin
            state_d = S_IDLE;
            done_d  = 1'b1;
         end
         default: state_d = S_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q  <= S_IDLE;
         link_q   <= 1'b0;
         mode_q   <= 1'b0;
         done     <= 1'b0;
         tmo_flag <= 1'b0;
      end else begin
         state_q <= state_d;
         link_q  <= link_d;
         done    <= done_d;
         if (start_ok) begin
            mode_q   <= cmd_mode;
            tmo_flag <= 1'b0;
         end else if (tmo_set) begin
            tmo_flag <= 1'b1;
         end
      end
   end

   psc_pin_map u_pins (
      .state         (state_q),
      .mode3         (mode_q),
      .link_tx       (link_q),
      .data_oe       (data_oe),
      .data_hold_hi  (data_hold_hi),
      .sclk_oe       (sclk_oe),
      .sclk_run      (sclk_run),
      .sclk_force_hi (sclk_force_hi),
      .tgt_rst_low   (tgt_rst_low)
   );

   assign link_dir_tx = link_q;
   assign session_on  = (state_q != S_IDLE);
   assign busy        = (state_q != S_IDLE) && (state_q != S_ACTIVE);
endmodule

// File: rtl/prog_session_chk.sv
module prog_session_chk #(
   parameter int DATA_HI_CYC = 1,
   parameter int RST_LO_CYC  = 1
) (
   input logic clk,
   input logic rst_n,
   input logic cmd_start,
   input logic mode3,
   input logic tx_busy,
   input logic session_on,
   input logic busy,
   input logic done,
   input logic tmo_flag,
   input logic data_oe,
   input logic sclk_oe,
   input logic sclk_run,
   input logic sclk_force_hi,
   input logic tgt_rst_low
);
   int   pre_cnt;
   logic seen_run;

   // counts setup cycles of the current session before the clock first runs
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pre_cnt  <= 0;
         seen_run <= 1'b0;
      end else if (!session_on) begin
         pre_cnt  <= 0;
         seen_run <= 1'b0;
      end else if (sclk_run) begin
         seen_run <= 1'b1;
      end else if (!seen_run) begin
         pre_cnt <= pre_cnt + 1;
      end
   end

   p_idle_released_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !session_on |-> (!data_oe && !sclk_oe && !sclk_run && !sclk_force_hi && !tgt_rst_low));

   p_setup_two_wire_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (session_on && sclk_run && !seen_run && !mode3) |-> (pre_cnt >= DATA_HI_CYC));

   p_setup_three_wire_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (session_on && sclk_run && !seen_run && mode3) |-> (pre_cnt >= RST_LO_CYC));

   p_rst_held_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (session_on && mode3) |-> tgt_rst_low);

   p_tmo_release_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(tmo_flag) |-> !session_on);

   p_tmo_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(tmo_flag) |-> $past(cmd_start));

   p_drain_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_busy && data_oe) |=> data_oe);

   p_clk_exclusive_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({sclk_run, sclk_force_hi}));

   p_done_not_busy_r11: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy);
endmodule

bind prog_session_ctrl prog_session_chk #(
   .DATA_HI_CYC (DATA_HI_CYC),
   .RST_LO_CYC  (RST_LO_CYC)
) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .cmd_start     (cmd_start),
   .mode3         (mode_q),
   .tx_busy       (tx_busy),
   .session_on    (session_on),
   .busy          (busy),
   .done          (done),
   .tmo_flag      (tmo_flag),
   .data_oe       (data_oe),
   .sclk_oe       (sclk_oe),
   .sclk_run      (sclk_run),
   .sclk_force_hi (sclk_force_hi),
   .tgt_rst_low   (tgt_rst_low)
);

// File: tb/prog_session_ctrl_tb.sv
`timescale 1ns/1ps
module prog_session_ctrl_tb;
   localparam int EXP_2W  = (90 * 1000 + 3999) / 4000;   // 23 cycles
   localparam int EXP_3W  = (400 * 1000 + 3999) / 4000;  // 100 cycles
   localparam int EXP_BRK = 24;
   localparam int TMO     = 100;

   // {mode3, scenario[1:0], expect_timeout}; scenario 0 reply, 1 silent, 2 line low
   localparam logic [3:0] VEC [6] = '{
      4'b0_00_0, 4'b1_00_0, 4'b0_01_1, 4'b1_01_1, 4'b1_10_1, 4'b0_10_1
   };

   logic clk = 1'b0, rst_n = 1'b0;
   logic cmd_start = 0, cmd_mode = 0, cmd_stop = 0, rx_req = 0, tx_req = 0;
   logic bit_tick = 0, ms_tick = 0, tx_busy = 0, frame_done = 0, data_in = 0;
   logic data_oe, data_hold_hi, link_dir_tx, sclk_oe, sclk_run, sclk_force_hi;
   logic tgt_rst_low, session_on, busy, done, tmo_flag;

   int n_chk = 0, n_bad = 0;
   bit finished = 0;

   always #2 clk = ~clk;

   prog_session_ctrl u_dut (.*);

   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic released(input string req);
      check(!data_oe && !sclk_oe && !sclk_run && !sclk_force_hi && !tgt_rst_low && !session_on,
            req, {data_oe, sclk_oe, sclk_run, sclk_force_hi, tgt_rst_low, session_on}, 0);
   endtask

   task automatic ms_pulse();
      @(negedge clk) ms_tick = 1;
      @(negedge clk) ms_tick = 0;
   endtask

   // start and measure setup: returns count of clock-stopped cycles
   task automatic do_entry(input logic m, output int setup_n, output bit pins_ok);
      @(negedge clk) begin cmd_start = 1; cmd_mode = m; end
      @(negedge clk) cmd_start = 0;
      setup_n = 0; pins_ok = 1;
      for (int i = 0; i < 400; i++) begin
         if (sclk_run) break;
         if (!(data_oe && data_hold_hi && (tgt_rst_low == m))) pins_ok = 0;
         setup_n++;
         @(negedge clk);
      end
   endtask

   task automatic run_breaks(output int ticks, output bit held);
      bit ph = 1;
      ticks = 0; held = 1;
      for (int i = 0; i < 200; i++) begin
         if (done) break;
         if (!(data_oe && data_hold_hi && sclk_run)) held = 0;
         bit_tick = ph;
         if (ph) ticks++;
         ph = !ph;
         @(negedge clk);
      end
      bit_tick = 0;
   endtask

   initial begin
      #(4 * 150000);
      if (!finished) begin
         n_bad++;
         $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
         $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      int sn, tk;
      bit ok, hl;
      repeat (3) @(negedge clk);
      // R1 reset state
      released("R1");
      check(!busy && !done && !tmo_flag, "R1 status", {busy, done, tmo_flag}, 0);
      rst_n = 1;
      @(negedge clk);

      foreach (VEC[v]) begin
         logic m;
         logic [1:0] sc;
         m  = VEC[v][3];
         sc = VEC[v][2:1];
         do_entry(m, sn, ok);
         if (m) check(sn >= EXP_3W && ok, "R3 setup", sn, EXP_3W);
         else   check(sn >= EXP_2W && ok, "R2 setup", sn, EXP_2W);
         check(!tmo_flag, "R7 cleared on start", tmo_flag, 0);
         run_breaks(tk, hl);
         check(tk == EXP_BRK && hl, "R4 break bits", tk, EXP_BRK);
         check(link_dir_tx && session_on && !busy && data_oe, "R4 active tx",
               {link_dir_tx, session_on, busy, data_oe}, 4'b1101);
         check(tgt_rst_low == m, "R3 reset level", tgt_rst_low, m);

         data_in = (sc != 2'd2);
         tx_busy = 1;
         @(negedge clk) rx_req = 1;
         @(negedge clk) rx_req = 0;
         repeat (3) @(negedge clk);
         check(data_oe && busy, "R5 drain holds data", {data_oe, busy}, 3);
         tx_busy = 0;
         @(negedge clk);
         @(negedge clk);
         check(!data_oe && sclk_run, "R5 data released", {data_oe, sclk_run}, 1);
         repeat (6) @(negedge clk);

         if (sc == 2'd0) begin
            @(negedge clk) frame_done = 1;
            @(negedge clk) frame_done = 0;
            check(done == 1, "R6 done on frame", done, 1);
            check(session_on && !link_dir_tx && !data_oe && !tmo_flag, "R6 rx idle",
                  {session_on, link_dir_tx, data_oe, tmo_flag}, 4'b1000);
         end else begin
            repeat (TMO - 1) ms_pulse();
            check(session_on && !tmo_flag, sc == 2'd1 ? "R6 no early tmo" : "R5 no early tmo",
                  {session_on, tmo_flag}, 2);
            ms_pulse();
            @(negedge clk);
            check(tmo_flag && !session_on, sc == 2'd1 ? "R6 tmo" : "R5 tmo",
                  {tmo_flag, session_on}, 2);
            released("R7 release");
         end

         if (!VVEC_TMO(VEC[v])) begin
            @(negedge clk) cmd_stop = 1;
            @(negedge clk) cmd_stop = 0;
            if (!m) begin
               @(negedge clk);
               check(sclk_force_hi && sclk_oe && !sclk_run && !data_oe, "R9 hold",
                     {sclk_force_hi, sclk_oe, sclk_run, data_oe}, 4'b1100);
               ms_pulse();
               check(sclk_force_hi, "R9 hold after one tick", sclk_force_hi, 1);
               ms_pulse();
               @(negedge clk);
               check(done == 1, "R9 done", done, 1);
               released("R9 release");
            end else begin
               check(tgt_rst_low, "R10 reset during drain", tgt_rst_low, 1);
               @(negedge clk);
               check(done == 1, "R10 done", done, 1);
               released("R10 release");
            end
         end
         repeat (4) @(negedge clk);
      end

      // R7 sticky flag after the last timeout
      repeat (20) @(negedge clk);
      check(tmo_flag, "R7 sticky", tmo_flag, 1);

      // R11 commands ignored while busy; start also clears the flag (R7)
      @(negedge clk) begin cmd_start = 1; cmd_mode = 0; end
      @(negedge clk) begin cmd_start = 1; cmd_mode = 1; cmd_stop = 1; end
      check(!tmo_flag, "R7 clear", tmo_flag, 0);
      @(negedge clk) begin cmd_start = 0; cmd_stop = 0; end
      check(busy && !tgt_rst_low && !sclk_run, "R11 start ignored",
            {busy, tgt_rst_low, sclk_run}, 4);
      for (int i = 0; i < 60; i++) begin
         if (sclk_run) break;
         @(negedge clk);
      end
      run_breaks(tk, hl);
      repeat (3) @(negedge clk);
      check(session_on && !busy && !tgt_rst_low, "R11 stop ignored",
            {session_on, busy, tgt_rst_low}, 4);

      // R12 rx from rx direction, then tx_req
      data_in = 1;
      @(negedge clk) rx_req = 1;
      @(negedge clk) rx_req = 0;
      repeat (6) @(negedge clk);
      @(negedge clk) frame_done = 1;
      @(negedge clk) frame_done = 0;
      @(negedge clk) rx_req = 1;
      @(negedge clk) rx_req = 0;
      check(busy && !data_oe, "R12 direct wait", {busy, data_oe}, 2);
      @(negedge clk) frame_done = 1;
      @(negedge clk) frame_done = 0;
      check(done && !link_dir_tx, "R12 second byte", {done, link_dir_tx}, 2);
      @(negedge clk) tx_req = 1;
      @(negedge clk) tx_req = 0;
      check(link_dir_tx && data_oe && !busy, "R12 tx dir", {link_dir_tx, data_oe, busy}, 6);

      // R8 stop waits for the transmitter, R11 start ignored during hold
      tx_busy = 1;
      @(negedge clk) cmd_stop = 1;
      @(negedge clk) cmd_stop = 0;
      repeat (5) @(negedge clk);
      check(data_oe && busy && !sclk_force_hi, "R8 drain wait", {data_oe, busy, sclk_force_hi}, 6);
      tx_busy = 0;
      @(negedge clk);
      @(negedge clk);
      check(!data_oe && sclk_force_hi, "R8 released", {data_oe, sclk_force_hi}, 1);
      @(negedge clk) begin cmd_start = 1; cmd_mode = 1; end
      @(negedge clk) cmd_start = 0;
      check(sclk_force_hi && !tgt_rst_low, "R11 start in hold", {sclk_force_hi, tgt_rst_low}, 2);
      ms_pulse();
      ms_pulse();
      @(negedge clk);
      released("R9 final release");

      finished = 1;
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end

   function automatic bit VVEC_TMO(input logic [3:0] e);
      return e[0];
   endfunction
endmodule